// File: doc/BRIEF.md
# Buffered PWM Channel with Selectable Polarity

This block is one pulse-width-modulated output channel of a timer. An up-counter moves forward once for each pulse on a clock-enable input. It counts from zero to one less than a programmed period and then wraps to zero. The output starts each period at its idle level. It switches to the opposite level when the counter reaches the programmed duty value, and it returns to idle when the counter wraps. A polarity bit decides which level is idle and which is active.

Software programs the block through a small write port. The port holds three registers: period, duty, and a control word with the enable and polarity bits. The duty value last written can always be read back. While the channel runs, new period and duty values wait in a holding stage. They reach the comparator only when the counter wraps, or when the channel is switched off. This means a period already under way is never cut short or stretched. Every degenerate setting of duty, period and polarity gives a fixed, defined output level.

Top module: `pwm_buf_chan`

## Requirements
- R1: After reset the duty readback is 0xFF, the channel is disabled, polarity is 0 and `pwm_out` is low.
- R2: `rd_duty` shows the value of the most recent duty write (`wr_sel`=1) from the cycle after that write onward, even while that value is still pending.
- R3: With polarity 0, period P>0 and duty D<P, the counter runs 0..P-1 and then wraps. After k ticks from enable, `pwm_out` is high exactly when (k mod P) >= D.
- R4: With polarity 1, the output of R3 is inverted.
- R5: A duty write made while enabled does not change the output until the counter next wraps to zero. From then on the new duty applies.
- R6: A period write made while enabled does not change the counting until the counter next wraps. From then on the new period applies.
- R7: While disabled (control bit 0 = 0), the counter is held at zero, `pwm_out` equals the polarity bit, and period/duty writes become active at once. Enabling starts the count from zero.
- R8: With duty 0 and period above 0, an enabled channel holds `pwm_out` at the inverse of the polarity bit.
- R9: With duty at or above period, `pwm_out` equals the polarity bit at all times.
- R10: With period 0, `pwm_out` equals the polarity bit whatever the duty.
- R11: A polarity change (control bit 1) alters `pwm_out` in the cycle after the write, with no wait for a wrap.
- R12: The counter advances only in cycles where `tick` is high. Without ticks the output stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Clock enable that advances the counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 duty, 2 control |
| wr_data | input | 8 | Write data; for control, bit 0 enable, bit 1 polarity |
| rd_duty | output | 8 | Last duty value written |
| pwm_out | output | 1 | PWM output |

## Verification
The active compare values and the counter cannot be seen directly. A wrong value in any of them shows up at `pwm_out` as a misplaced edge, and it does so within one period of ticks. For that reason every period/duty/polarity combination of a small range is swept, and the output is compared at every tick across two full periods. A buffer that loads too early or too late moves an edge either in the period where the write was made or in the next one. The bench checks both periods around the wrap.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;
  typedef enum logic [1:0] {
    SEL_PER = 2'd0,
    SEL_DTY = 2'd1,
    SEL_CTL = 2'd2
  } wsel_e;

  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_POL_BIT = 1;
endpackage

// File: rtl/pwm_buf_regs.sv
module pwm_buf_regs
  import pwm_buf_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] per_nxt,
  output logic [W-1:0] dty_nxt,
  output logic [W-1:0] dty_rd,
  output logic         en,
  output logic         pol
);
  logic [W-1:0] per_q, dty_q;
  logic         en_q, pol_q, en_d, pol_d;

  always_comb begin
    per_nxt = per_q;
    dty_nxt = dty_q;
    en_d    = en_q;
    pol_d   = pol_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_PER: per_nxt = wr_data;
        SEL_DTY: dty_nxt = wr_data;
        SEL_CTL: begin
          en_d  = wr_data[CTL_EN_BIT];
          pol_d = wr_data[CTL_POL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '1;
      dty_q <= '1;
      en_q  <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      per_q <= per_nxt;
      dty_q <= dty_nxt;
      en_q  <= en_d;
      pol_q <= pol_d;
    end
  end

  assign dty_rd = dty_q;
  assign en     = en_q;
  assign pol    = pol_q;

  // R2
  dty_readback_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == SEL_DTY) |=> dty_rd == $past(wr_data));
endmodule

// File: rtl/pwm_buf_timebase.sv
module pwm_buf_timebase #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick,
  input  logic         en,
  input  logic [W-1:0] per_nxt,
  input  logic [W-1:0] dty_nxt,
  output logic [W-1:0] cnt,
  output logic [W-1:0] act_per,
  output logic [W-1:0] act_dty
);
  logic [W-1:0] cnt_q, cnt_d, per_q, per_d, dty_q, dty_d;
  logic         last, roll;

  always_comb begin
    last = (per_q == '0) || (cnt_q == per_q - W'(1));
    roll = en && tick && last;

    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = last ? '0 : cnt_q + W'(1);

    per_d = per_q;
    dty_d = dty_q;
    if (!en || roll) begin
      per_d = per_nxt;
      dty_d = dty_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '1;
      dty_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      dty_q <= dty_d;
    end
  end

  assign cnt     = cnt_q;
  assign act_per = per_q;
  assign act_dty = dty_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && act_per != '0) |-> cnt < act_per);
  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> cnt == '0);
  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && !roll) |=> ($stable(act_dty) && $stable(act_per)));
  // R12
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && !tick) |=> $stable(cnt));
endmodule

// File: rtl/pwm_buf_outgen.sv
module pwm_buf_outgen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         en,
  input  logic         pol,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] act_per,
  input  logic [W-1:0] act_dty,
  output logic         pwm_o
);
  logic post;

  always_comb begin
    post  = en && (act_per != '0) && (act_dty < act_per) && (cnt >= act_dty);
    pwm_o = post ^ pol;
  end

  // R10
  zero_per_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (act_per == '0) |-> pwm_o == pol);
  // R9
  dty_over_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (act_dty >= act_per) |-> pwm_o == pol);
  // R8
  dty_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && act_per != '0 && act_dty == '0) |-> pwm_o == !pol);
endmodule

// File: rtl/pwm_buf_chan.sv
module pwm_buf_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_duty,
  output logic         pwm_out
);
  logic [1:0]   rst_sync_q;
  logic         rst_ni;
  logic [W-1:0] per_nxt, dty_nxt, cnt, act_per, act_dty;
  logic         en, pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pwm_buf_regs #(.W(W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .per_nxt(per_nxt), .dty_nxt(dty_nxt),
    .dty_rd(rd_duty), .en(en), .pol(pol)
  );

  pwm_buf_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .en(en),
    .per_nxt(per_nxt), .dty_nxt(dty_nxt),
    .cnt(cnt), .act_per(act_per), .act_dty(act_dty)
  );

  pwm_buf_outgen #(.W(W)) u_out (
    .clk(clk), .rst_ni(rst_ni), .en(en), .pol(pol), .cnt(cnt),
    .act_per(act_per), .act_dty(act_dty), .pwm_o(pwm_out)
  );
endmodule

// File: tb/pwm_buf_chan_bench.sv
`timescale 1ns/1ps
module pwm_buf_chan_bench;
  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data, rd_duty;
  logic       pwm_out;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pwm_buf_chan u_pwm_buf_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_duty(rd_duty), .pwm_out(pwm_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic exp_out(input int p, input int d, input int k, input logic pol);
    logic post;
    post = (p > 0) && (d < p) && ((k % ((p > 0) ? p : 1)) >= d);
    return post ^ pol;
  endfunction

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rd_duty, 8'hFF, "R1 duty reset");
    check({7'd0, pwm_out}, 8'd0, "R1 out reset");

    // Sweep: R3 R4 R8 R9 R10 R7
    for (int p = 0; p <= 6; p++)
      for (int d = 0; d <= 7; d++)
        for (int pl = 0; pl <= 1; pl++) begin
          string tg;
          tg = (p == 0) ? "R10" : (d == 0) ? "R8" : (d >= p) ? "R9" : (pl != 0) ? "R4" : "R3";
          wr(2'd0, 8'(p));
          wr(2'd1, 8'(d));
          check(rd_duty, 8'(d), "R2 readback");
          wr(2'd2, {6'd0, 1'(pl), 1'b1});
          check({7'd0, pwm_out}, {7'd0, exp_out(p, d, 0, 1'(pl))}, tg);
          for (int k = 1; k <= 2 * p + 2; k++) begin
            step(1);
            check({7'd0, pwm_out}, {7'd0, exp_out(p, d, k, 1'(pl))}, tg);
          end
          wr(2'd2, {6'd0, 1'(pl), 1'b0});
          step(2);
          check({7'd0, pwm_out}, {7'd0, 1'(pl)}, "R7 disabled level");
        end

    // R5 buffered duty
    wr(2'd0, 8'd8); wr(2'd1, 8'd2); wr(2'd2, 8'h01);
    step(3);
    wr(2'd1, 8'd6);
    check(rd_duty, 8'd6, "R2 pending readback");
    step(2); // cnt 5
    check({7'd0, pwm_out}, 8'd1, "R5 old duty kept");
    step(3); // wrap, cnt 0
    for (int k = 0; k < 8; k++) begin
      check({7'd0, pwm_out}, {7'd0, exp_out(8, 6, k, 1'b0)}, "R5 new duty");
      step(1);
    end
    wr(2'd2, 8'h00);

    // R6 buffered period
    wr(2'd0, 8'd8); wr(2'd1, 8'd2); wr(2'd2, 8'h01);
    step(5);
    wr(2'd0, 8'd4);
    step(2); // cnt 7 under old period
    check({7'd0, pwm_out}, 8'd1, "R6 old period kept");
    step(1); // wrap
    for (int k = 0; k <= 8; k++) begin
      check({7'd0, pwm_out}, {7'd0, exp_out(4, 2, k, 1'b0)}, "R6 new period");
      step(1);
    end

    // R11 immediate polarity, R12 no advance without tick
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd8); wr(2'd1, 8'd2); wr(2'd2, 8'h01);
    step(3);
    check({7'd0, pwm_out}, 8'd1, "R11 before flip");
    wr(2'd2, 8'h03);
    check({7'd0, pwm_out}, 8'd0, "R11 after flip");
    repeat (6) @(negedge clk);
    check({7'd0, pwm_out}, 8'd0, "R12 frozen");
    step(5); // 3+5 = 8 -> cnt 0, pre level for pol 1
    check({7'd0, pwm_out}, 8'd1, "R12 count resumed");

    // R7 disable applies pending duty at once
    wr(2'd1, 8'd7);
    wr(2'd2, 8'h00);
    check({7'd0, pwm_out}, 8'd0, "R7 disabled pol0");
    wr(2'd2, 8'h01);
    step(6);
    check({7'd0, pwm_out}, 8'd0, "R7 new duty after disable");
    step(1);
    check({7'd0, pwm_out}, 8'd1, "R7 match at new duty");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule